// File: doc/BRIEF.md
# Dual Watchdog Reset Unit

This block supervises a processor with two watchdog timers that run side by side and share one reset request output. The first timer counts an operating clock that runs at half the oscillator rate. Software starts it through a small register write port, and the same write picks its timeout from four settings. The second timer counts the oscillator clock directly. Its timeout is fixed, and a configuration input that stays constant during operation enables it.

Software keeps the system alive by issuing a service strobe. The strobe clears both counters. If either timer reaches its terminal count first, the block raises the reset request for a fixed number of oscillator cycles. That internal reset also clears the counters and turns off the software-started timer. Once software starts that timer, its enable and its timeout setting are locked until the next reset, so a runaway program cannot switch it off.

Top module: `dual_wdt`

## Requirements
- R1: While `porN` is low, and afterwards as long as neither watchdog is enabled, `rstReq` stays 0.
- R2: With `fixedEnable` = 1 and no service, `rstReq` rises exactly 2^FIXED_BITS oscillator edges after the counter starts from zero. The counter starts from zero after power-on reset, or after a reset pulse ends.
- R3: With `fixedEnable` = 0, the fixed watchdog never requests a reset.
- R4: A write with `cfgWr` = 1 and `cfgEnable` = 1 starts the programmable watchdog. Its timeout is 2^(PROG_BASE_BITS + 2·`cfgRate`) operating-clock cycles, with `cfgRate` 0, 1, 2 and 3 selecting 2^B, 2^(B+2), 2^(B+4) and 2^(B+6).
- R5: The operating clock is the oscillator divided by two. Measured from the write edge, the programmable timeout is therefore 2L−1 or 2L oscillator edges for a timeout of L operating cycles.
- R6: A `serviceWr` pulse clears both counters on that edge, and a timeout is never signalled on that same edge. Servicing at intervals shorter than both timeouts keeps `rstReq` at 0.
- R7: Once the programmable watchdog is running, further writes to its enable or rate are ignored until the next reset.
- R8: Each timeout drives `rstReq` high for exactly 4 consecutive oscillator cycles, starting the cycle after the terminal edge.
- R9: The reset pulse turns off the programmable watchdog and clears both counters. After a programmable timeout with the fixed watchdog disabled, no further reset occurs.
- R10: With both watchdogs enabled, the one with the shorter remaining time triggers the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| fixedEnable | input | 1 | Configuration enable for the fixed-timeout watchdog, held constant while running |
| cfgWr | input | 1 | Control write strobe for the programmable watchdog |
| cfgEnable | input | 1 | Enable value written with `cfgWr` |
| cfgRate | input | 2 | Timeout select written with `cfgWr` |
| serviceWr | input | 1 | Service strobe that clears both counters |
| rstReq | output | 1 | System reset request |

## Verification
A counter that skips or sticks shows up at the port as a reset pulse that arrives too early, too late or never. The bench measures that arrival to the exact oscillator edge for the fixed timer, and within the half-rate phase for each programmable rate. A lock bit or rate register that gives way to a later write would move the next pulse by hundreds of cycles, so it is caught on the first timeout after the write. A pulse-length counter that is off by one changes the width of the very first reset pulse. A cycle-accurate model in the bench flags any divergence in the first cycle it appears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from control to datapath, one per oscillator cycle.
  typedef struct packed {
    logic clrCounters;  // service or active reset pulse
    logic progTick;     // one operating-clock cycle elapsed with the programmable watchdog on
  } wdtStrobe_t;

  localparam int RATE_SELECTS = 4;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int FIXED_BITS     = 18,
  parameter int PROG_BASE_BITS = 15
) (
  input  logic       clk,
  input  logic       porN,
  input  wdtStrobe_t strobe,
  input  logic [1:0] progRate,
  input  logic       fixedEnable,
  output logic       progTimeout,
  output logic       fixedTimeout
);
  localparam int PROG_W = PROG_BASE_BITS + 2 * (RATE_SELECTS - 1);

  logic [PROG_W-1:0]       progCnt;
  logic [FIXED_BITS-1:0]   fixedCnt;
  logic [RATE_SELECTS-1:0] rateHit;

  // Terminal-count detector for every selectable timeout.
  for (genvar g = 0; g < RATE_SELECTS; g++) begin : gRate
    localparam int TERM_BITS = PROG_BASE_BITS + 2 * g;
    localparam logic [PROG_W-1:0] TERM = PROG_W'((64'd1 << TERM_BITS) - 64'd1);
    assign rateHit[g] = (progCnt == TERM);
  end

  assign progTimeout  = strobe.progTick && !strobe.clrCounters && rateHit[progRate];
  assign fixedTimeout = fixedEnable && !strobe.clrCounters && (&fixedCnt);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      progCnt  <= '0;
      fixedCnt <= '0;
    end else if (strobe.clrCounters) begin
      progCnt  <= '0;
      fixedCnt <= '0;
    end else begin
      if (strobe.progTick) progCnt  <= progCnt + 1'b1;
      if (fixedEnable)     fixedCnt <= fixedCnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int RST_PULSE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       cfgWr,
  input  logic       cfgEnable,
  input  logic [1:0] cfgRate,
  input  logic       serviceWr,
  input  logic       progTimeout,
  input  logic       fixedTimeout,
  output wdtStrobe_t strobe,
  output logic [1:0] progRate,
  output logic       rstReq
);
  localparam int PULSE_W = $clog2(RST_PULSE_CYCLES + 1);
  localparam logic [PULSE_W-1:0] PULSE_LOAD = PULSE_W'(RST_PULSE_CYCLES);

  logic               opPhase;
  logic               progEn;
  logic [PULSE_W-1:0] pulseCnt;
  logic               rstActive;

  assign rstActive          = (pulseCnt != '0);
  assign strobe.clrCounters = serviceWr || rstActive;
  assign strobe.progTick    = progEn && opPhase;
  assign rstReq             = rstActive;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      opPhase  <= 1'b0;
      progEn   <= 1'b0;
      progRate <= 2'b00;
      pulseCnt <= '0;
    end else begin
      opPhase <= ~opPhase;

      if (progTimeout || fixedTimeout) pulseCnt <= PULSE_LOAD;
      else if (rstActive)              pulseCnt <= pulseCnt - 1'b1;

      if (rstActive) begin
        progEn   <= 1'b0;
        progRate <= 2'b00;
      end else if (cfgWr && !progEn) begin
        progEn   <= cfgEnable;
        progRate <= cfgRate;
      end
    end
  end
endmodule

// File: rtl/dual_wdt.sv
module dual_wdt
  import wdt_pkg::*;
#(
  parameter int FIXED_BITS       = 18,
  parameter int PROG_BASE_BITS   = 15,
  parameter int RST_PULSE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       fixedEnable,
  input  logic       cfgWr,
  input  logic       cfgEnable,
  input  logic [1:0] cfgRate,
  input  logic       serviceWr,
  output logic       rstReq
);
  wdtStrobe_t strobe;
  logic [1:0] progRate;
  logic       progTimeout;
  logic       fixedTimeout;

  wdt_ctrl #(.RST_PULSE_CYCLES(RST_PULSE_CYCLES)) u_ctrl (
    .clk(clk), .porN(porN), .cfgWr(cfgWr), .cfgEnable(cfgEnable),
    .cfgRate(cfgRate), .serviceWr(serviceWr), .progTimeout(progTimeout),
    .fixedTimeout(fixedTimeout), .strobe(strobe), .progRate(progRate),
    .rstReq(rstReq)
  );

  wdt_datapath #(.FIXED_BITS(FIXED_BITS), .PROG_BASE_BITS(PROG_BASE_BITS)) u_dp (
    .clk(clk), .porN(porN), .strobe(strobe), .progRate(progRate),
    .fixedEnable(fixedEnable), .progTimeout(progTimeout),
    .fixedTimeout(fixedTimeout)
  );
endmodule

// File: rtl/dual_wdt_checker.sv
module dual_wdt_checker (
  input logic clk,
  input logic porN,
  input logic rstReq,
  input logic serviceWr
);
  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!porN)
    $rose(rstReq) |=> rstReq); // R8

  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!porN)
    $rose(rstReq) |-> ##4 !rstReq); // R8

  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!porN)
    $rose(rstReq) |-> ##3 rstReq); // R8

  AST_SERVICE_BLOCKS: assert property (@(posedge clk) disable iff (!porN)
    serviceWr |=> !$rose(rstReq)); // R6

  always @(posedge clk) begin
    AST_QUIET_IN_POR: assert (porN || !rstReq); // R1
  end
endmodule

bind dual_wdt dual_wdt_checker u_chk (
  .clk(clk), .porN(porN), .rstReq(rstReq), .serviceWr(serviceWr)
);

// File: tb/dual_wdt_tb.sv
module dual_wdt_tb;
  localparam int FB = 9;
  localparam int PB = 3;
  localparam int FLIM = 1 << FB;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic fixedEnable = 1'b0;
  logic cfgWr = 1'b0;
  logic cfgEnable = 1'b0;
  logic [1:0] cfgRate = 2'b00;
  logic serviceWr = 1'b0;
  logic rstReq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_wdt #(.FIXED_BITS(FB), .PROG_BASE_BITS(PB), .RST_PULSE_CYCLES(4)) u_dut (
    .clk(clk), .porN(porN), .fixedEnable(fixedEnable), .cfgWr(cfgWr),
    .cfgEnable(cfgEnable), .cfgRate(cfgRate), .serviceWr(serviceWr),
    .rstReq(rstReq)
  );

  // Cycle model built from the requirements.
  logic       mPhase, mEn;
  logic [1:0] mRate;
  int         mProg, mFix, mPulse;

  function automatic int progTicks(input logic [1:0] r);
    return 1 << (PB + 2 * r);
  endfunction

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mPhase <= 0; mEn <= 0; mRate <= 0; mProg <= 0; mFix <= 0; mPulse <= 0;
    end else begin
      automatic bit act = (mPulse != 0);
      automatic bit clr = serviceWr || act;
      automatic bit tk  = mEn && mPhase;
      automatic bit pTo = tk && !clr && (mProg == progTicks(mRate) - 1);
      automatic bit fTo = fixedEnable && !clr && (mFix == FLIM - 1);
      mPhase <= ~mPhase;
      if (pTo || fTo) mPulse <= 4;
      else if (act)   mPulse <= mPulse - 1;
      if (act) begin mEn <= 0; mRate <= 0; end
      else if (cfgWr && !mEn) begin mEn <= cfgEnable; mRate <= cfgRate; end
      if (clr) begin mProg <= 0; mFix <= 0; end
      else begin
        if (tk) mProg <= mProg + 1;
        if (fixedEnable) mFix <= mFix + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Advance one edge; compare against the model away from the edge.
  task automatic step();
    @(negedge clk);
    check(rstReq === (mPulse != 0), "R6 cycle model", int'(rstReq), int'(mPulse != 0));
  endtask

  task automatic por(input logic fe);
    @(negedge clk);
    porN = 0; fixedEnable = fe; cfgWr = 0; serviceWr = 0;
    @(negedge clk);
    check(rstReq === 1'b0, "R1 during POR", int'(rstReq), 0);
    @(negedge clk);
    porN = 1;
  endtask

  task automatic writeCfg(input logic en, input logic [1:0] r);
    cfgWr = 1; cfgEnable = en; cfgRate = r;
    step();
    cfgWr = 0;
  endtask

  task automatic waitRise(output int n, input int limit);
    n = 0;
    while (n < limit) begin
      step(); n++;
      if (rstReq) break;
    end
  endtask

  task automatic pulseWidth(input string req);
    int h = 1;
    while (h < 20) begin
      step();
      if (!rstReq) break;
      h++;
    end
    check(h == 4, req, h, 4);
  endtask

  task automatic stayLow(input int cycles, input string req);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (rstReq) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    int n, l;
    void'($urandom(32'h5eed_1234));

    // Reset state and idle with nothing enabled.
    por(1'b0);
    check(rstReq === 1'b0, "R1 after POR", int'(rstReq), 0);
    stayLow(2 * FLIM + 100, "R3 fixed disabled no reset");

    // Each programmable rate.
    for (int r = 0; r < 4; r++) begin
      por(1'b0);
      l = progTicks(2'(r));
      writeCfg(1'b1, 2'(r));
      waitRise(n, 4 * l + 10);
      check(n == 2 * l || n == 2 * l - 1, $sformatf("R4 R5 rate %0d timeout", r), n, 2 * l);
      pulseWidth("R8 pulse width prog");
      stayLow(2 * l + 50, "R9 prog off after reset");
    end

    // Fixed watchdog, two consecutive periods.
    por(1'b1);
    waitRise(n, 2 * FLIM);
    check(n == FLIM, "R2 fixed timeout first", n, FLIM);
    pulseWidth("R8 pulse width fixed");
    waitRise(n, 2 * FLIM);
    check(n == FLIM, "R2 fixed timeout repeat", n, FLIM);
    pulseWidth("R8 pulse width fixed repeat");

    // Regular service keeps both quiet.
    por(1'b1);
    writeCfg(1'b1, 2'd0);
    for (int i = 0; i < 3000; i++) begin
      serviceWr = (i % 10 == 0);
      step();
      if (rstReq) begin check(1'b0, "R6 serviced no reset", 1, 0); break; end
    end
    serviceWr = 0;
    check(rstReq === 1'b0, "R6 serviced end", int'(rstReq), 0);

    // Lock: later writes do not disable or shorten.
    por(1'b0);
    writeCfg(1'b1, 2'd3);
    writeCfg(1'b0, 2'd0);
    writeCfg(1'b1, 2'd0);
    waitRise(n, 4000);
    n += 2;
    l = progTicks(2'd3);
    check(n == 2 * l || n == 2 * l - 1, "R7 lock keeps rate", n, 2 * l);
    pulseWidth("R8 pulse after lock");

    // Both enabled: shorter wins.
    por(1'b1);
    writeCfg(1'b1, 2'd1);
    waitRise(n, 4000);
    l = progTicks(2'd1);
    check(n == 2 * l || n == 2 * l - 1, "R10 prog first", n, 2 * l);
    por(1'b1);
    writeCfg(1'b1, 2'd3);
    waitRise(n, 4000);
    check(n == FLIM - 1, "R10 fixed first", n, FLIM - 1);

    // Random traffic against the cycle model.
    for (int s = 0; s < 8; s++) begin
      por(1'($urandom_range(0, 1)));
      for (int i = 0; i < 2500; i++) begin
        cfgWr     = ($urandom_range(0, 199) == 0);
        cfgEnable = 1'($urandom_range(0, 1));
        cfgRate   = 2'($urandom_range(0, 3));
        serviceWr = ($urandom_range(0, 39) == 0);
        step();
      end
      cfgWr = 0; serviceWr = 0;
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule